// File: doc/BRIEF.md
# Controller-Change Voice Parameter Writer

This block takes controller-change packets, each carrying a type, a channel, a controller number and a value. It turns each packet into byte writes to a memory that holds one parameter record per voice. There are 26 voices, and each record is 287 bytes long. The target byte address is the channel times the record size, plus an offset that depends on the controller number.

The block handles each controller number in one of four ways:
- It stores the value byte as it is.
- It maps the value through a parameterised loudness table. A zero input produces a dedicated mute code.
- It applies a fixed arithmetic transform to the value.
- It sets or clears one bit of a shared 16-bit flags word. This takes a read-modify-write of both bytes of the word.

A packet with an out-of-range channel is dropped without any memory access. A packet with an unknown controller number is dropped, and the block reports it on a one-cycle pulse output. The block takes only one packet at a time. The packet input stays not-ready until every memory access for the current packet has finished.

Top module: `cc_voice_writer`

## Requirements
- R1: A packet is the 32-bit word `pkt_data`, with type in bits 31:24, channel in 23:16, controller number in 15:8 and value in 7:0. A packet is accepted on a clock edge where `pkt_valid` and `pkt_ready` are both high. The type byte has no effect.
- R2: A packet whose channel is 26 or more causes no memory read, no memory write and no ignore pulse.
- R3: Every access targets channel × 287 + offset. A 16-bit field puts its high byte at the offset and its low byte at offset + 1, and the high byte is written first.
- R4: Controller 0x07 writes a 16-bit table value at offset 0x74, and controller 0x0B writes one at offset 0x78. The table is indexed by value bits 6:0. The default table entry for index v is (v × v × 4) mod 65536.
- R5: For controllers 0x07 and 0x0B, when value bits 6:0 are zero, the block writes the mute code 0xFE00 instead of the table entry.
- R6: Controllers 0x0A, 0x91 and 0x97 write the value as a single byte at offsets 0x76, 0x7F and 0x80, and touch no other byte.
- R7: Controller 0x7C writes (value − 128) × 2, as a 16-bit two's-complement word, at offset 0x7C.
- R8: Controller 0x7D writes (value − 64) mod 256 as a single byte at offset 0x7E.
- R9: Controllers 0x40 and 0x95 update the flags word at offset 0x72. Controller 0x40 acts on bit 0 and controller 0x95 on bit 2. The bit is set when the value is 64 or more and cleared otherwise, and all other bits keep their old values. Both bytes are read before either byte is written.
- R10: A packet on a valid channel with any other controller number causes no memory access. It drives `ign_pulse` high for exactly one cycle, starting the cycle after acceptance.
- R11: Memory read data is expected one cycle after `mem_rd`. Reads and writes never occur together. `pkt_ready` is low from the cycle after acceptance until the last access ends, which gives these busy cycles:
  - 5 cycles for a flag update;
  - 2 cycles for a 16-bit write;
  - 1 cycle for a byte write;
  - 0 cycles for a dropped packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Packet present |
| pkt_ready | output | 1 | Block can accept a packet |
| pkt_data | input | 32 | Packet: type, channel, controller, value |
| mem_addr | output | AW (13) | Byte address into the voice records |
| mem_wr | output | 1 | Byte write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rd | output | 1 | Byte read strobe |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| ign_pulse | output | 1 | One-cycle pulse for an unmapped controller |

## Verification
The assertions check the following on every cycle:
- Dropped channels produce no access.
- The mute code appears as the first two write bytes.
- A flag update follows the exact read-read-gap-write pattern.
- Addresses stay inside the record space.
- Reads and writes stay exclusive.
- The input stays not-ready while memory is busy.

Only the bench's scenarios can show that the stored bytes are right: the table values, the signed transforms, and flag bits that are preserved across a read-modify-write of a pre-filled memory. The same holds for the busy-cycle counts seen at the handshake and for the absence of stray writes next to single-byte fields.

// File: rtl/cc_voice_pkg.sv
package cc_voice_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_BYTE,
        OP_LOUD,
        OP_BEND,
        OP_CENTER,
        OP_FLAG
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_HI,
        ST_RD_LO,
        ST_RD_CAP,
        ST_WR_HI,
        ST_WR_LO
    } st_e;

    localparam int          LOUD_ENTRIES = 128;
    localparam int          LOUD_WIDTH   = 16;
    localparam logic [15:0] MUTE_CODE    = 16'hFE00;
    localparam logic [7:0]  FLAG_ON_MIN  = 8'd64;
    localparam logic [7:0]  CENTER_BIAS  = 8'd64;

    // Record offsets
    localparam logic [8:0] OFS_FLAGS  = 9'h072;
    localparam logic [8:0] OFS_LEVEL  = 9'h074;
    localparam logic [8:0] OFS_PAN    = 9'h076;
    localparam logic [8:0] OFS_EXPR   = 9'h078;
    localparam logic [8:0] OFS_BEND   = 9'h07C;
    localparam logic [8:0] OFS_CENTER = 9'h07E;
    localparam logic [8:0] OFS_SEND_A = 9'h07F;
    localparam logic [8:0] OFS_SEND_B = 9'h080;

    function automatic logic [LOUD_ENTRIES*LOUD_WIDTH-1:0] default_loud_table();
        logic [LOUD_ENTRIES*LOUD_WIDTH-1:0] t;
        t = '0;
        for (int i = 0; i < LOUD_ENTRIES; i++) begin
            t[i*LOUD_WIDTH +: LOUD_WIDTH] = 16'(i * i * 4);
        end
        return t;
    endfunction

endpackage

// File: rtl/cc_decode.sv
module cc_decode
    import cc_voice_pkg::*;
(
    input  logic [7:0] ctrl,
    output op_e        op,
    output logic [8:0] offset,
    output logic [3:0] flag_bit
);
    always_comb begin
        op       = OP_NONE;
        offset   = '0;
        flag_bit = '0;
        unique case (ctrl)
            8'h07: begin op = OP_LOUD;   offset = OFS_LEVEL;  end
            8'h0B: begin op = OP_LOUD;   offset = OFS_EXPR;   end
            8'h0A: begin op = OP_BYTE;   offset = OFS_PAN;    end
            8'h91: begin op = OP_BYTE;   offset = OFS_SEND_A; end
            8'h97: begin op = OP_BYTE;   offset = OFS_SEND_B; end
            8'h7C: begin op = OP_BEND;   offset = OFS_BEND;   end
            8'h7D: begin op = OP_CENTER; offset = OFS_CENTER; end
            8'h40: begin op = OP_FLAG;   offset = OFS_FLAGS; flag_bit = 4'd0; end
            8'h95: begin op = OP_FLAG;   offset = OFS_FLAGS; flag_bit = 4'd2; end
            default: ;
        endcase
    end
endmodule

// File: rtl/cc_addr_calc.sv
module cc_addr_calc #(
    parameter int NUM_VOICES = 26,
    parameter int REC_BYTES  = 287,
    parameter int AW         = 13
) (
    input  logic [7:0]    chan,
    input  logic [8:0]    offset,
    output logic          chan_ok,
    output logic [AW-1:0] addr
);
    always_comb begin
        chan_ok = (int'(chan) < NUM_VOICES);
        addr    = AW'(chan) * AW'(REC_BYTES) + AW'(offset);
    end
endmodule

// File: rtl/cc_value_xform.sv
module cc_value_xform
    import cc_voice_pkg::*;
#(
    parameter logic [LOUD_ENTRIES*LOUD_WIDTH-1:0] LOUD_TABLE = default_loud_table()
) (
    input  op_e         op,
    input  logic [7:0]  val,
    input  logic [3:0]  flag_bit,
    input  logic [15:0] old_word,
    output logic [15:0] word
);
    logic [15:0] mask;
    logic [15:0] bend;

    always_comb begin
        mask = 16'd1 << flag_bit;
        bend = (16'(val) - 16'd128) << 1;
        unique case (op)
            OP_LOUD:   word = (val[6:0] == 7'd0) ? MUTE_CODE
                                                 : LOUD_TABLE[{val[6:0], 4'b0000} +: LOUD_WIDTH];
            OP_BEND:   word = bend;
            OP_CENTER: word = {8'h00, val - CENTER_BIAS};
            OP_FLAG:   word = (val >= FLAG_ON_MIN) ? (old_word | mask) : (old_word & ~mask);
            OP_BYTE:   word = {8'h00, val};
            default:   word = '0;
        endcase
    end
endmodule

// File: rtl/cc_voice_writer.sv
module cc_voice_writer
    import cc_voice_pkg::*;
#(
    parameter int NUM_VOICES = 26,
    parameter int REC_BYTES  = 287,
    parameter int AW         = $clog2(NUM_VOICES * REC_BYTES),
    parameter logic [LOUD_ENTRIES*LOUD_WIDTH-1:0] LOUD_TABLE = default_loud_table()
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_valid,
    output logic          pkt_ready,
    input  logic [31:0]   pkt_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_wr,
    output logic [7:0]    mem_wdata,
    output logic          mem_rd,
    input  logic [7:0]    mem_rdata,
    output logic          ign_pulse
);
    localparam int TOTAL_BYTES = NUM_VOICES * REC_BYTES;

    typedef struct packed {
        st_e           st;
        op_e           op;
        logic [AW-1:0] addr;
        logic          wide;
        logic [15:0]   word;
        logic [7:0]    val;
        logic [3:0]    fbit;
        logic [7:0]    rd_hi;
        logic          ign;
    } state_t;

    state_t q, d;

    logic [7:0]    in_chan, in_ctrl, in_val;
    logic          unused_type;
    op_e           dec_op;
    logic [8:0]    dec_ofs;
    logic [3:0]    dec_fbit;
    logic          chan_ok;
    logic [AW-1:0] calc_addr;
    op_e           x_op;
    logic [7:0]    x_val;
    logic [3:0]    x_fbit;
    logic [15:0]   x_word;
    logic          accept;

    assign in_chan     = pkt_data[23:16];
    assign in_ctrl     = pkt_data[15:8];
    assign in_val      = pkt_data[7:0];
    assign unused_type = ^pkt_data[31:24];
    assign pkt_ready   = (q.st == ST_IDLE);
    assign accept      = pkt_valid && pkt_ready;
    assign ign_pulse   = q.ign;

    cc_decode u_dec (
        .ctrl     (in_ctrl),
        .op       (dec_op),
        .offset   (dec_ofs),
        .flag_bit (dec_fbit)
    );

    cc_addr_calc #(
        .NUM_VOICES (NUM_VOICES),
        .REC_BYTES  (REC_BYTES),
        .AW         (AW)
    ) u_addr (
        .chan    (in_chan),
        .offset  (dec_ofs),
        .chan_ok (chan_ok),
        .addr    (calc_addr)
    );

    // In idle the transform works on the incoming packet, later on the latched one.
    always_comb begin
        if (q.st == ST_IDLE) begin
            x_op   = dec_op;
            x_val  = in_val;
            x_fbit = dec_fbit;
        end else begin
            x_op   = q.op;
            x_val  = q.val;
            x_fbit = q.fbit;
        end
    end

    cc_value_xform #(
        .LOUD_TABLE (LOUD_TABLE)
    ) u_xform (
        .op       (x_op),
        .val      (x_val),
        .flag_bit (x_fbit),
        .old_word ({q.rd_hi, mem_rdata}),
        .word     (x_word)
    );

    always_comb begin
        d         = q;
        d.ign     = 1'b0;
        mem_wr    = 1'b0;
        mem_rd    = 1'b0;
        mem_addr  = q.addr;
        mem_wdata = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (accept && chan_ok) begin
                    if (dec_op == OP_NONE) begin
                        d.ign = 1'b1;
                    end else begin
                        d.op   = dec_op;
                        d.addr = calc_addr;
                        d.val  = in_val;
                        d.fbit = dec_fbit;
                        d.word = x_word;
                        d.wide = (dec_op == OP_LOUD) || (dec_op == OP_BEND) || (dec_op == OP_FLAG);
                        if (dec_op == OP_FLAG)
                            d.st = ST_RD_HI;
                        else if (d.wide)
                            d.st = ST_WR_HI;
                        else
                            d.st = ST_WR_LO;
                    end
                end
            end
            ST_RD_HI: begin
                mem_rd = 1'b1;
                d.st   = ST_RD_LO;
            end
            ST_RD_LO: begin
                mem_rd   = 1'b1;
                mem_addr = q.addr + AW'(1);
                d.rd_hi  = mem_rdata;
                d.st     = ST_RD_CAP;
            end
            ST_RD_CAP: begin
                d.word = x_word;
                d.st   = ST_WR_HI;
            end
            ST_WR_HI: begin
                mem_wr    = 1'b1;
                mem_wdata = q.word[15:8];
                d.st      = ST_WR_LO;
            end
            ST_WR_LO: begin
                mem_wr    = 1'b1;
                mem_addr  = q.addr + (q.wide ? AW'(1) : AW'(0));
                mem_wdata = q.word[7:0];
                d.st      = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, op: OP_NONE, default: '0};
        end else begin
            q <= d;
        end
    end

    // Assertions
    assert_bad_chan_no_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready && (int'(pkt_data[23:16]) >= NUM_VOICES))
        |=> (!mem_wr && !mem_rd && !ign_pulse && pkt_ready));

    assert_mute_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready && (int'(pkt_data[23:16]) < NUM_VOICES)
         && (pkt_data[15:8] == 8'h07 || pkt_data[15:8] == 8'h0B) && pkt_data[6:0] == 7'd0)
        |=> (mem_wr && mem_wdata == 8'hFE) ##1 (mem_wr && mem_wdata == 8'h00));

    assert_flag_rmw_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready && (int'(pkt_data[23:16]) < NUM_VOICES)
         && (pkt_data[15:8] == 8'h40 || pkt_data[15:8] == 8'h95))
        |=> mem_rd ##1 mem_rd ##1 (!mem_rd && !mem_wr) ##1 mem_wr ##1 mem_wr);

    assert_unmapped_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && chan_ok && dec_op == OP_NONE)
        |=> (ign_pulse && !mem_wr && !mem_rd) ##1 !ign_pulse);

    assert_addr_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || mem_rd) |-> (int'(mem_addr) < TOTAL_BYTES));

    assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || mem_rd) |-> (!pkt_ready && !(mem_wr && mem_rd)));

endmodule

// File: tb/cc_voice_writer_tb.sv
module cc_voice_writer_tb;
    localparam int AW = 13;
    localparam int NV = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pkt_valid = 1'b0;
    logic          pkt_ready;
    logic [31:0]   pkt_data = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_wr, mem_rd, ign_pulse;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;

    logic [7:0] mem [0:8191];
    int wr_cnt = 0, rd_cnt = 0, ign_cnt = 0, cyc = 0;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    cc_voice_writer u_dut (
        .clk (clk), .rst_n (rst_n),
        .pkt_valid (pkt_valid), .pkt_ready (pkt_ready), .pkt_data (pkt_data),
        .mem_addr (mem_addr), .mem_wr (mem_wr), .mem_wdata (mem_wdata),
        .mem_rd (mem_rd), .mem_rdata (mem_rdata), .ign_pulse (ign_pulse)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 8192; i++) mem[i] <= 8'(i * 7 + 3);
            mem_rdata <= '0;
        end else begin
            if (mem_wr) begin mem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
            if (mem_rd) begin mem_rdata <= mem[mem_addr]; rd_cnt <= rd_cnt + 1; end
            if (ign_pulse) ign_cnt <= ign_cnt + 1;
        end
        if (cyc > 100000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // {type, channel, controller, value}
    localparam logic [31:0] VEC [NV] = '{
        {8'h00, 8'd0,   8'h07, 8'd100},
        {8'h12, 8'd5,   8'h07, 8'd0},
        {8'hA5, 8'd25,  8'h0B, 8'd127},
        {8'h3C, 8'd25,  8'h0B, 8'h80},
        {8'h01, 8'd3,   8'h0A, 8'd64},
        {8'hFF, 8'd7,   8'h91, 8'd127},
        {8'h00, 8'd7,   8'h97, 8'd5},
        {8'h00, 8'd2,   8'h7C, 8'd0},
        {8'h77, 8'd2,   8'h7C, 8'hFF},
        {8'h00, 8'd4,   8'h7D, 8'h10},
        {8'h00, 8'd9,   8'h40, 8'd64},
        {8'h00, 8'd9,   8'h95, 8'd100},
        {8'h00, 8'd9,   8'h40, 8'd63},
        {8'h00, 8'd1,   8'h33, 8'd9}
    };

    task automatic run_pkt(input logic [31:0] pkt);
        int chan, ctrl, v, base, ofs, nbytes, exp_w, exp_busy, exp_ign, busy;
        int w0, r0, i0, old_w, oth;
        string req;
        chan = pkt[23:16]; ctrl = pkt[15:8]; v = pkt[7:0];
        base = chan * 287; ofs = 0; nbytes = 0; exp_w = 0; exp_busy = 0; exp_ign = 0;
        req = "R10";
        if (chan >= 26) begin
            req = "R2";
        end else begin
            old_w = {mem[base + 'h72], mem[base + 'h73]};
            case (ctrl)
                'h07, 'h0B: begin
                    req = (v % 128 == 0) ? "R5" : "R4";
                    ofs = (ctrl == 'h07) ? 'h74 : 'h78; nbytes = 2; exp_busy = 2;
                    exp_w = (v % 128 == 0) ? 'hFE00 : ((v % 128) * (v % 128) * 4) % 65536;
                end
                'h0A, 'h91, 'h97: begin
                    req = "R6"; nbytes = 1; exp_busy = 1; exp_w = v;
                    ofs = (ctrl == 'h0A) ? 'h76 : (ctrl == 'h91) ? 'h7F : 'h80;
                end
                'h7C: begin req = "R7"; ofs = 'h7C; nbytes = 2; exp_busy = 2;
                            exp_w = ((v - 128) * 2) & 'hFFFF; end
                'h7D: begin req = "R8"; ofs = 'h7E; nbytes = 1; exp_busy = 1;
                            exp_w = (v - 64) & 'hFF; end
                'h40, 'h95: begin
                    req = "R9"; ofs = 'h72; nbytes = 2; exp_busy = 5;
                    oth = (ctrl == 'h40) ? 1 : 4;
                    exp_w = (v >= 64) ? (old_w | oth) : (old_w & ~oth & 'hFFFF);
                end
                default: exp_ign = 1;
            endcase
        end
        oth = mem[(base + ofs + 1) % 8192];
        w0 = wr_cnt; r0 = rd_cnt; i0 = ign_cnt;
        @(negedge clk);
        pkt_valid = 1'b1; pkt_data = pkt;
        @(negedge clk);
        pkt_valid = 1'b0;
        busy = 0;
        while (!pkt_ready) begin busy++; @(negedge clk); end
        @(negedge clk);
        chk(busy == exp_busy, {req, "/R11 busy cycles"}, busy, exp_busy);
        chk(wr_cnt - w0 == nbytes, {req, " write count"}, wr_cnt - w0, nbytes);
        chk(ign_cnt - i0 == exp_ign, {req, " ignore pulses"}, ign_cnt - i0, exp_ign);
        if (nbytes == 0)
            chk(rd_cnt == r0, {req, " no reads"}, rd_cnt - r0, 0);
        if (nbytes == 2)
            chk({mem[base + ofs], mem[base + ofs + 1]} == 16'(exp_w), {req, "/R3 word"},
                {mem[base + ofs], mem[base + ofs + 1]}, exp_w);
        if (nbytes == 1) begin
            chk(mem[base + ofs] == 8'(exp_w), {req, "/R3 byte"}, mem[base + ofs], exp_w);
            chk(mem[base + ofs + 1] == 8'(oth), {req, " neighbour byte"}, mem[base + ofs + 1], oth);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(pkt_ready == 1'b0 || pkt_ready == 1'b1, "R1 reset ready known", pkt_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pkt_ready == 1'b1, "R1 ready after reset", pkt_ready, 1);
        chk(!mem_wr && !mem_rd && !ign_pulse, "R11 idle after reset", {mem_wr, mem_rd, ign_pulse}, 0);

        for (int k = 0; k < NV; k++) run_pkt(VEC[k]);

        // Directed corner cases
        run_pkt({8'h00, 8'd26, 8'h07, 8'd50});   // R2: first invalid channel
        run_pkt({8'h00, 8'd255, 8'h40, 8'd127}); // R2: largest channel
        run_pkt({8'h5A, 8'd9, 8'h95, 8'd0});     // R9: clear bit 2
        run_pkt({8'h00, 8'd25, 8'hFF, 8'd1});    // R10: unmapped on last voice
        run_pkt({8'hEE, 8'd0, 8'h07, 8'd1});     // R1: type byte has no effect, R4 smallest entry

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule